// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block resolves a guest virtual address into a system physical address after the translation buffer has missed. The guest operating system's four-level table turns the guest virtual address into a guest physical address. Every pointer that table yields is itself a guest physical address, so the walker must first push it through a second four-level table, owned by the hypervisor, before it can fetch anything from memory. The table base of each guest level, and finally the data page, therefore costs a complete nested walk of its own. A fully populated miss issues 24 entry reads.

The requester presents an address along with the translation buffer's hit result. On a hit, the cached system address comes straight back and no memory is touched. On a miss, the walker drives a memory read port that allows one request in flight at a time. A missing entry in either table stops the walk. The response then names the table that lacked the entry and the level at which the entry was missing. Both table roots are configuration inputs and are sampled when a request is accepted.

Top module: `twd_walker`

## Requirements
- R1: A request with the hit flag set returns `req_hit_spa` in the cycle after acceptance with the fault flag clear, and issues no memory read. `reads_issued` then reads 0.
- R2: On a miss, the response address is the nested translation of the final guest physical address. Its upper part is the leaf nested entry's frame, and its low 12 bits are `req_gva[11:0]`.
- R3: A miss with every entry present issues exactly 24 memory reads. `reads_issued` reports the number of reads accepted by the memory port since the request was accepted.
- R4: The first read of a miss goes to the nested root plus 8 times the level-3 index of the guest root. Level L (3 = top, 0 = leaf) indexes with address bits [12+9L+8 : 12+9L], and entries are 8 bytes.
- R5: If a guest entry has bit 0 clear, the response has the fault flag set, `rsp_fault_nested` at 0 and `rsp_fault_level` equal to that guest level. No further read follows.
- R6: If a nested entry has bit 0 clear, the response has the fault flag set, `rsp_fault_nested` at 1 and `rsp_fault_level` equal to that nested level.
- R7: Only one read is in flight at a time. A request that is not yet taken keeps its address until `mem_req_ready` takes it.
- R8: A request is accepted only when `busy` is low. `busy` rises in the cycle after acceptance and stays high through the cycle in which `rsp_valid` is high. Requests raised while busy have no effect and produce no response.
- R9: Only bits 51:12 (frame) and bit 0 (present) of an entry are used. Bits 63:52 and 11:1 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_gva | input | 48 | Guest virtual address |
| req_tlb_hit | input | 1 | Translation buffer hit for this request |
| req_hit_spa | input | 52 | Cached system physical address on a hit |
| guest_root | input | 52 | Guest table root (guest physical) |
| nest_root | input | 52 | Nested table root (system physical) |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_spa | output | 52 | Resulting system physical address |
| rsp_fault | output | 1 | Walk aborted on a missing entry |
| rsp_fault_nested | output | 1 | 1 = nested table fault, 0 = guest table fault |
| rsp_fault_level | output | 2 | Level of the missing entry |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 52 | Entry address (system physical) |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry data |
| reads_issued | output | 5 | Reads taken during the current or last walk |

## Verification
The hardest conditions to reach from the ports are faults deep inside the walk. These include a guest entry absent at an inner level after three complete nested walks have already succeeded, and a nested entry absent only on the final data-page translation. The bench builds both table trees itself in a sparse memory model, allocating frames as it maps chosen addresses. A second address that shares the upper indices of a mapped one but differs at bits 29:21 therefore fails at guest level 1 after 15 reads. A leaf entry that points at a guest frame never placed in the nested table fails at nested level 3 after 21 reads. A stalling ready pattern and a request raised in the middle of a walk cover the handshake and acceptance rules.

// File: rtl/twd_pkg.sv
package twd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_NREQ  = 3'd1,
    ST_NWAIT = 3'd2,
    ST_GREQ  = 3'd3,
    ST_GWAIT = 3'd4,
    ST_RESP  = 3'd5
  } walk_state_e;
endpackage

// File: rtl/twd_rst_sync.sv
module twd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/twd_idx_sel.sv
module twd_idx_sel #(
  parameter int ADDR_W = 48,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LVL_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LVL_W-1:0]  lvl,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] slice [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign slice[g] = addr[OFF_W + g*IDX_W +: IDX_W];
  end

  assign idx = slice[lvl];
endmodule

// File: rtl/twd_read_cnt.sv
module twd_read_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr || (inc && (count != '1));
    count_d  = clr ? '0 : count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end
endmodule

// File: rtl/twd_walker.sv
module twd_walker
  import twd_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int ENT_W  = 64,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_gva,
  input  logic              req_tlb_hit,
  input  logic [PA_W-1:0]   req_hit_spa,
  input  logic [PA_W-1:0]   guest_root,
  input  logic [PA_W-1:0]   nest_root,
  output logic              busy,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_spa,
  output logic              rsp_fault,
  output logic              rsp_fault_nested,
  output logic [1:0]        rsp_fault_level,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic [CNT_W-1:0]  reads_issued
);
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int STG_W   = $clog2(LEVELS + 1);
  localparam int ENT_SH  = $clog2(ENT_W / 8);

  logic rst_i_n;

  walk_state_e        state_q, state_d;
  logic [VA_W-1:0]    gva_q, gva_d;
  logic [FRAME_W-1:0] nroot_q, nroot_d;
  logic [PA_W-1:0]    gpa_q, gpa_d;
  logic [FRAME_W-1:0] nptr_q, nptr_d;
  logic [FRAME_W-1:0] gtab_q, gtab_d;
  logic [STG_W-1:0]   gstep_q, gstep_d;
  logic [LVL_W-1:0]   nlvl_q, nlvl_d;
  logic [PA_W-1:0]    spa_q, spa_d;
  logic               flt_q, flt_d;
  logic               fnest_q, fnest_d;
  logic [LVL_W-1:0]   flvl_q, flvl_d;
  logic               walk_en, rsp_en, cnt_clr;

  logic [LVL_W-1:0]   glvl;
  logic [IDX_W-1:0]   nidx, gidx;
  logic               ent_present;
  logic [FRAME_W-1:0] ent_frame;
  logic               last_guest;
  logic               ent_unused;

  twd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign glvl = LVL_W'(LEVELS - 1) - gstep_q[LVL_W-1:0];

  twd_idx_sel #(.ADDR_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W))
    u_nidx (.addr(gpa_q[VA_W-1:0]), .lvl(nlvl_q), .idx(nidx));

  twd_idx_sel #(.ADDR_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W))
    u_gidx (.addr(gva_q), .lvl(glvl), .idx(gidx));

  assign ent_present = mem_rsp_data[0];
  assign ent_frame   = mem_rsp_data[PA_W-1:OFF_W];
  assign last_guest  = (gstep_q == STG_W'(LEVELS - 1));
  assign ent_unused  = ^{mem_rsp_data[ENT_W-1:PA_W], mem_rsp_data[OFF_W-1:1],
                         gpa_q[PA_W-1:VA_W], guest_root[OFF_W-1:0], nest_root[OFF_W-1:0]};

  always_comb begin
    state_d = state_q;
    gva_d   = gva_q;
    nroot_d = nroot_q;
    gpa_d   = gpa_q;
    nptr_d  = nptr_q;
    gtab_d  = gtab_q;
    gstep_d = gstep_q;
    nlvl_d  = nlvl_q;
    spa_d   = spa_q;
    flt_d   = flt_q;
    fnest_d = fnest_q;
    flvl_d  = flvl_q;
    walk_en = 1'b0;
    rsp_en  = 1'b0;
    cnt_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          walk_en = 1'b1;
          cnt_clr = 1'b1;
          gva_d   = req_gva;
          nroot_d = nest_root[PA_W-1:OFF_W];
          if (req_tlb_hit) begin
            rsp_en  = 1'b1;
            spa_d   = req_hit_spa;
            flt_d   = 1'b0;
            fnest_d = 1'b0;
            flvl_d  = '0;
            state_d = ST_RESP;
          end else begin
            gpa_d   = {guest_root[PA_W-1:OFF_W], OFF_W'(0)};
            gstep_d = '0;
            nlvl_d  = LVL_W'(LEVELS - 1);
            nptr_d  = nest_root[PA_W-1:OFF_W];
            state_d = ST_NREQ;
          end
        end
      end
      ST_NREQ: if (mem_req_ready) state_d = ST_NWAIT;
      ST_GREQ: if (mem_req_ready) state_d = ST_GWAIT;
      ST_NWAIT: begin
        if (mem_rsp_valid) begin
          walk_en = 1'b1;
          if (!ent_present) begin
            rsp_en  = 1'b1;
            spa_d   = '0;
            flt_d   = 1'b1;
            fnest_d = 1'b1;
            flvl_d  = nlvl_q;
            state_d = ST_RESP;
          end else if (nlvl_q != '0) begin
            nptr_d  = ent_frame;
            nlvl_d  = nlvl_q - LVL_W'(1);
            state_d = ST_NREQ;
          end else if (gstep_q == STG_W'(LEVELS)) begin
            rsp_en  = 1'b1;
            spa_d   = {ent_frame, gpa_q[OFF_W-1:0]};
            flt_d   = 1'b0;
            fnest_d = 1'b0;
            flvl_d  = '0;
            state_d = ST_RESP;
          end else begin
            gtab_d  = ent_frame;
            state_d = ST_GREQ;
          end
        end
      end
      ST_GWAIT: begin
        if (mem_rsp_valid) begin
          walk_en = 1'b1;
          if (!ent_present) begin
            rsp_en  = 1'b1;
            spa_d   = '0;
            flt_d   = 1'b1;
            fnest_d = 1'b0;
            flvl_d  = glvl;
            state_d = ST_RESP;
          end else begin
            gpa_d   = {ent_frame, last_guest ? gva_q[OFF_W-1:0] : OFF_W'(0)};
            gstep_d = gstep_q + STG_W'(1);
            nlvl_d  = LVL_W'(LEVELS - 1);
            nptr_d  = nroot_q;
            state_d = ST_NREQ;
          end
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      gva_q   <= '0;
      nroot_q <= '0;
      gpa_q   <= '0;
      nptr_q  <= '0;
      gtab_q  <= '0;
      gstep_q <= '0;
      nlvl_q  <= '0;
    end else if (walk_en) begin
      gva_q   <= gva_d;
      nroot_q <= nroot_d;
      gpa_q   <= gpa_d;
      nptr_q  <= nptr_d;
      gtab_q  <= gtab_d;
      gstep_q <= gstep_d;
      nlvl_q  <= nlvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      spa_q   <= '0;
      flt_q   <= 1'b0;
      fnest_q <= 1'b0;
      flvl_q  <= '0;
    end else if (rsp_en) begin
      spa_q   <= spa_d;
      flt_q   <= flt_d;
      fnest_q <= fnest_d;
      flvl_q  <= flvl_d;
    end
  end

  twd_read_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .clr(cnt_clr),
    .inc(mem_req_valid && mem_req_ready), .count(reads_issued)
  );

  assign busy             = (state_q != ST_IDLE);
  assign rsp_valid        = (state_q == ST_RESP);
  assign rsp_spa          = spa_q;
  assign rsp_fault        = flt_q;
  assign rsp_fault_nested = fnest_q;
  assign rsp_fault_level  = 2'(flvl_q);
  assign mem_req_valid    = (state_q == ST_NREQ) || (state_q == ST_GREQ);
  assign mem_req_addr     = (state_q == ST_GREQ)
                          ? {gtab_q, OFF_W'(0)} + (PA_W'(gidx) << ENT_SH)
                          : {nptr_q, OFF_W'(0)} + (PA_W'(nidx) << ENT_SH);
endmodule

// File: rtl/twd_walker_chk.sv
module twd_walker_chk #(
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic             rsp_fault_nested,
  input logic             mem_req_valid,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_req_ready,
  input logic             mem_rsp_valid,
  input logic [CNT_W-1:0] reads_issued
);
  localparam int MAX_READS = (LEVELS + 1) * LEVELS + LEVELS;

  logic inflight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           inflight_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) inflight_q <= 1'b1;
    else if (mem_rsp_valid)               inflight_q <= 1'b0;
  end

  assert_one_inflight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> !mem_req_valid);

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_read_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  assert_read_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reads_issued <= CNT_W'(MAX_READS));

  assert_ok_read_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (reads_issued == '0 || reads_issued == CNT_W'(MAX_READS)));

  assert_busy_covers_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_read_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  assert_nested_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> !rsp_fault_nested);
endmodule

bind twd_walker twd_walker_chk #(.PA_W(PA_W), .LEVELS(LEVELS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_fault_nested(rsp_fault_nested), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
  .mem_rsp_valid(mem_rsp_valid), .reads_issued(reads_issued)
);

// File: tb/twd_walker_test.sv
`timescale 1ns/1ps
module twd_walker_test;
  typedef logic [51:0] pa_t;
  typedef logic [39:0] fr_t;

  logic        clk, rst_n;
  logic        req_valid, req_tlb_hit;
  logic [47:0] req_gva;
  pa_t         req_hit_spa, guest_root, nest_root;
  logic        busy, rsp_valid, rsp_fault, rsp_fault_nested;
  pa_t         rsp_spa, mem_req_addr;
  logic [1:0]  rsp_fault_level;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic [4:0]  reads_issued;

  twd_walker uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;

  logic [63:0] mem [pa_t];
  fr_t         g2s [fr_t];
  pa_t         hs_addr [int];
  int          hs_cnt = 0;
  fr_t         s_next = 40'h1000, g_next = 40'h200;
  fr_t         groot_f = 40'h1000_0005, nroot_f = 40'h10;
  bit          stall = 0, pend = 0, rdy_t = 0;
  int          pend_dly = 0;
  pa_t         pend_a;

  function automatic logic [63:0] rd(pa_t a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] mk(fr_t f);
    return {12'hA5C, f, 11'h2AA, 1'b1};
  endfunction

  always @(negedge clk) begin
    cycles++;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (pend_dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(pend_a);
        pend = 0;
      end else pend_dly--;
    end
    rdy_t = ~rdy_t;
    mem_req_ready <= stall ? rdy_t : 1'b1;
    if (mem_req_valid && (stall ? rdy_t : 1'b1)) begin
      hs_addr[hs_cnt] = mem_req_addr;
      hs_cnt++;
      pend = 1;
      pend_dly = 1;
      pend_a = mem_req_addr;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic nmap(input fr_t gf, input fr_t sf);
    fr_t t = nroot_f;
    for (int l = 3; l >= 1; l--) begin
      pa_t a = {t, 12'h0} + 52'(gf[9*l +: 9]) * 8;
      logic [63:0] e;
      if (!rd(a)[0]) begin mem[a] = mk(s_next); s_next++; end
      e = rd(a);
      t = e[51:12];
    end
    mem[{t, 12'h0} + 52'(gf[8:0]) * 8] = mk(sf);
  endtask

  task automatic ensure(input fr_t gf, output fr_t sf);
    if (!g2s.exists(gf)) begin
      g2s[gf] = s_next; s_next++;
      nmap(gf, g2s[gf]);
    end
    sf = g2s[gf];
  endtask

  task automatic gmap(input logic [47:0] gva, input fr_t dgf, input bit map_data);
    fr_t t = groot_f, s;
    for (int l = 3; l >= 1; l--) begin
      pa_t a;
      logic [63:0] e;
      ensure(t, s);
      a = {s, 12'h0} + 52'(gva[12 + 9*l +: 9]) * 8;
      if (!rd(a)[0]) begin mem[a] = mk(g_next); g_next++; end
      e = rd(a);
      t = e[51:12];
    end
    ensure(t, s);
    mem[{s, 12'h0} + 52'(gva[20:12]) * 8] = mk(dgf);
    if (map_data) ensure(dgf, s);
  endtask

  pa_t r_spa, r_first;
  logic r_flt, r_nest, r_busy_rsp, r_busy_after;
  logic [1:0] r_lvl;
  int r_reads, r_hs, r_lat;

  task automatic do_req(input logic [47:0] gva, input logic hit, input pa_t hspa, input bit intrude);
    int base = hs_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_gva = gva; req_tlb_hit = hit; req_hit_spa = hspa;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0;
    while (!rsp_valid && r_lat < 2000) begin
      if (intrude && r_lat == 4) begin req_valid = 1'b1; req_gva = ~gva; req_tlb_hit = 1'b1; end
      if (intrude && r_lat == 7) req_valid = 1'b0;
      @(negedge clk);
      r_lat++;
    end
    req_valid = 1'b0;
    r_spa = rsp_spa; r_flt = rsp_fault; r_nest = rsp_fault_nested; r_lvl = rsp_fault_level;
    r_reads = int'(reads_issued); r_busy_rsp = busy;
    r_hs = hs_cnt - base;
    r_first = hs_addr.exists(base) ? hs_addr[base] : '0;
    @(negedge clk);
    r_busy_after = busy;
  endtask

  task automatic t_reset;
    chk("R8", "busy after reset", 64'(busy), 0);
    chk("R8", "rsp_valid after reset", 64'(rsp_valid), 0);
    chk("R7", "mem_req_valid after reset", 64'(mem_req_valid), 0);
  endtask

  task automatic t_hit;
    do_req(48'h1234_5678_9ABC, 1'b1, 52'hF_0000_1234_5ABC, 0);
    chk("R1", "hit latency", 64'(r_lat), 0);
    chk("R1", "hit spa", 64'(r_spa), 64'h0F_0000_1234_5ABC);
    chk("R1", "hit fault", 64'(r_flt), 0);
    chk("R1", "hit reads_issued", 64'(r_reads), 0);
    chk("R1", "hit memory handshakes", 64'(r_hs), 0);
  endtask

  task automatic t_walk(input logic [47:0] gva, input fr_t dgf, input string tag);
    pa_t exp;
    gmap(gva, dgf, 1);
    exp = {g2s[dgf], gva[11:0]};
    do_req(gva, 1'b0, '0, 0);
    chk("R2", {tag, " spa"}, 64'(r_spa), 64'(exp));
    chk("R2", {tag, " fault"}, 64'(r_flt), 0);
    chk("R3", {tag, " reads_issued"}, 64'(r_reads), 24);
    chk("R3", {tag, " memory handshakes"}, 64'(r_hs), 24);
    chk("R4", {tag, " first read address"}, 64'(r_first), 64'({nroot_f, 12'h0} + 52'd16));
    chk("R8", {tag, " busy in response cycle"}, 64'(r_busy_rsp), 1);
    chk("R8", {tag, " busy after response"}, 64'(r_busy_after), 0);
  endtask

  task automatic t_guest_fault;
    do_req(48'h0000_4020_1ABC ^ 48'h0000_0060_0000, 1'b0, '0, 0);
    chk("R5", "guest fault flag", 64'(r_flt), 1);
    chk("R5", "guest fault nested flag", 64'(r_nest), 0);
    chk("R5", "guest fault level", 64'(r_lvl), 1);
    chk("R5", "guest fault reads", 64'(r_reads), 15);
  endtask

  task automatic t_nested_fault;
    gmap(48'h0000_C000_3123, 40'h0_0FF0_0000, 0);
    do_req(48'h0000_C000_3123, 1'b0, '0, 0);
    chk("R6", "nested fault flag", 64'(r_flt), 1);
    chk("R6", "nested fault nested flag", 64'(r_nest), 1);
    chk("R6", "nested fault level", 64'(r_lvl), 3);
    chk("R6", "nested fault reads", 64'(r_reads), 21);
  endtask

  task automatic t_stall;
    stall = 1;
    gmap(48'h7FFF_FFFF_F00F, 40'h777, 1);
    do_req(48'h7FFF_FFFF_F00F, 1'b0, '0, 0);
    chk("R7", "stalled walk spa", 64'(r_spa), 64'({g2s[40'h777], 12'h00F}));
    chk("R7", "stalled walk reads", 64'(r_hs), 24);
    stall = 0;
  endtask

  task automatic t_busy_ignore;
    int extra;
    pa_t exp;
    gmap(48'h0000_0000_5FFF, 40'h999, 1);
    exp = {g2s[40'h999], 12'hFFF};
    do_req(48'h0000_0000_5FFF, 1'b0, '0, 1);
    chk("R8", "result with request raised while busy", 64'(r_spa), 64'(exp));
    chk("R8", "reads with request raised while busy", 64'(r_hs), 24);
    extra = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (rsp_valid || mem_req_valid) extra++;
    end
    chk("R8", "activity after ignored request", 64'(extra), 0);
  endtask

  initial begin
    req_valid = 0; req_gva = '0; req_tlb_hit = 0; req_hit_spa = '0;
    mem_req_ready = 1; mem_rsp_valid = 0; mem_rsp_data = '0;
    guest_root = {groot_f, 12'h0}; nest_root = {nroot_f, 12'h0};
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hit();
    t_walk(48'h0000_4020_1ABC, 40'h300, "R9 first");
    t_walk(48'h0000_4020_2001, 40'h301, "R9 shared upper tables");
    t_walk(48'hABCD_EF01_2345, 40'h555, "sparse");
    t_guest_fault();
    t_nested_fault();
    t_stall();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule